// File: doc/BRIEF.md
# LCD Common-Side Display Timing Generator

This block produces every timing signal that a dot-matrix LCD needs on its common (row) side when the row driver acts as the timing master. The block runs from one clock. From that clock it derives two offset operating clocks for the column drivers, a line shift clock, a scan-start bit that is shifted into the common shift register, a one-cycle frame marker and the AC-inversion signal, which flips the drive polarity on every frame.

The number of common lines per frame comes from a two-bit duty code. A new code is taken only at a frame boundary, so a frame in progress always runs to its full length. Each line lasts `LINE_CYC` clock cycles. When the master-select input is low, the generator is held at its starting point and all outputs rest in a fixed idle state. When master-select goes high again, a fresh frame starts, in the same way as after reset.

Top module: `lcd_com_timing`

## Requirements
- R1: The duty code sets the lines per frame as follows: code 2'b00 gives 48, 2'b01 gives 64, 2'b10 gives 96 and 2'b11 gives 128. The frame marker therefore repeats every lines x `LINE_CYC` clock cycles.
- R2: Starting the cycle after `master_en` is sampled low, `opclk_a` and `opclk_b` are high and `line_clk`, `frame_mark`, `scan_start` and `m_ac` are low. The first cycle after `master_en` is sampled high again is the first cycle of a new frame.
- R3: `opclk_a` and `opclk_b` are never low in the same cycle.
- R4: Each operating clock has a period of 4 clock cycles and is low for 1 of them. `opclk_b` goes low in the cycle after `opclk_a` was low. Counting from the first cycle of a run, `opclk_a` is low when the count modulo 4 is 1 and `opclk_b` is low when it is 2.
- R5: `line_clk` is low for the first `LINE_CYC/2` cycles of every line and high for the rest of the line, which gives one rising edge per line.
- R6: `m_ac` inverts in the first cycle of every frame after the first frame of a run, and it changes in no other cycle.
- R7: `frame_mark` is high for exactly one cycle, the first cycle of each frame.
- R8: `scan_start` is high for exactly the first line of each frame (`LINE_CYC` cycles). Because of this it is already high before that line's `line_clk` rising edge.
- R9: While `rst` is high, the outputs hold the idle state given in R2. After `rst` is released with `master_en` high, the first cycle starts a frame with `m_ac` low and both operating clocks high.
- R10: A duty code applied in the middle of a frame does not change the length of that frame. The next frame takes the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | 1 | High: generator runs; low: held idle |
| duty_sel | input | 2 | Lines-per-frame code |
| opclk_a | output | 1 | First column-driver operating clock |
| opclk_b | output | 1 | Second operating clock, one cycle behind |
| frame_mark | output | 1 | One-cycle pulse at each frame start |
| m_ac | output | 1 | Drive polarity, flips each frame |
| line_clk | output | 1 | Line shift clock, rises mid-line |
| scan_start | output | 1 | Scan bit for the common shift register |

## Verification
The assertions are written on the assumption that `master_en`, `rst` and `duty_sel` are stable around the clock edge, and that a change to `master_en` holds for at least two cycles. Under that assumption, an ordering check such as "the second clock falls after the first" cannot be cut apart by a mode change. The stimulus changes all inputs only on the falling edge. It holds slave mode for many cycles, and it changes the duty code both in mid-frame and right after a frame marker. The behavioural model in the bench counts cycles in integers, so its expectations do not depend on the ordering of the design's counters.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;

  localparam int unsigned ROW_W  = 8;
  localparam int unsigned NUM_PH = 2;
  localparam int unsigned PH_W   = 2;

  typedef logic [1:0]       duty_code_t;
  typedef logic [ROW_W-1:0] row_t;
  typedef logic [PH_W-1:0]  phase_t;

  // Lines per frame: 48 or 96 as a base, with one third added for odd codes.
  function automatic row_t rows_for_code(input duty_code_t code);
    row_t base;
    base = code[1] ? row_t'(96) : row_t'(48);
    return code[0] ? row_t'(base + base / row_t'(3)) : base;
  endfunction

  function automatic row_t last_row(input duty_code_t code);
    return rows_for_code(code) - row_t'(1);
  endfunction

  // Operating clock idx is low in the phase step idx+1.
  function automatic logic phase_low(input phase_t ph, input int unsigned idx);
    return ph == phase_t'(idx + 1);
  endfunction

endpackage

// File: rtl/lcd_com_phase.sv
module lcd_com_phase
  import lcd_com_pkg::*;
(
  input  logic              clk,
  input  logic              clear,
  input  logic              adv,
  output logic [NUM_PH-1:0] ph_clk
);

  phase_t ph_q;
  phase_t ph_n;

  always_comb begin
    if (clear)    ph_n = '0;
    else if (adv) ph_n = ph_q + phase_t'(1);
    else          ph_n = ph_q;
  end

  always_ff @(posedge clk) ph_q <= ph_n;

  // One registered output per operating clock, offset by index.
  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    always_ff @(posedge clk) begin
      ph_clk[i] <= clear ? 1'b1 : !phase_low(ph_n, i);
    end
  end

endmodule

// File: rtl/lcd_com_line.sv
module lcd_com_line #(
  parameter int unsigned LINE_CYC = 16
) (
  input  logic clk,
  input  logic clear,
  input  logic adv,
  output logic line_end,
  output logic line_head,
  output logic line_clk
);

  localparam int unsigned LC_W = $clog2(LINE_CYC);
  localparam logic [LC_W-1:0] LC_LAST = LC_W'(LINE_CYC - 1);
  localparam logic [LC_W-1:0] LC_HALF = LC_W'(LINE_CYC / 2);

  logic [LC_W-1:0] lc_q;
  logic [LC_W-1:0] lc_n;

  assign line_end = adv && (lc_q == LC_LAST);

  always_comb begin
    if (clear)         lc_n = '0;
    else if (line_end) lc_n = '0;
    else if (adv)      lc_n = lc_q + LC_W'(1);
    else               lc_n = lc_q;
  end

  assign line_head = (lc_n == '0);

  always_ff @(posedge clk) begin
    lc_q     <= lc_n;
    line_clk <= !clear && (lc_n >= LC_HALF);
  end

endmodule

// File: rtl/lcd_com_frame.sv
module lcd_com_frame
  import lcd_com_pkg::*;
(
  input  logic       clk,
  input  logic       clear,
  input  logic       line_end,
  input  logic       line_head,
  input  duty_code_t duty_sel,
  output logic       frame_end,
  output logic       frame_mark,
  output logic       scan_start,
  output logic       m_ac
);

  row_t       row_q, row_n;
  duty_code_t dsel_q, dsel_n;
  logic       m_q, m_n;

  assign frame_end = line_end && (row_q == last_row(dsel_q));

  always_comb begin
    row_n  = row_q;
    dsel_n = dsel_q;
    m_n    = m_q;
    if (clear) begin
      row_n  = '0;
      dsel_n = duty_sel;
      m_n    = 1'b0;
    end else if (frame_end) begin
      row_n  = '0;
      dsel_n = duty_sel;
      m_n    = !m_q;
    end else if (line_end) begin
      row_n  = row_q + row_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    row_q      <= row_n;
    dsel_q     <= dsel_n;
    m_q        <= m_n;
    scan_start <= !clear && (row_n == '0);
    frame_mark <= !clear && (row_n == '0) && line_head;
    m_ac       <= !clear && m_n;
  end

endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
  import lcd_com_pkg::*;
#(
  parameter int unsigned LINE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master_en,
  input  logic [1:0] duty_sel,
  output logic       opclk_a,
  output logic       opclk_b,
  output logic       frame_mark,
  output logic       m_ac,
  output logic       line_clk,
  output logic       scan_start
);

  // Named internal events, used by the checker.
  logic              clear_w;
  logic              adv_w;
  logic              line_end_w;
  logic              line_head_w;
  logic              frame_end_w;
  logic              started_q;
  logic [NUM_PH-1:0] ph_clk_w;

  assign clear_w = rst || !master_en;
  assign adv_w   = started_q && !clear_w;

  // The first running cycle shows the start state; later cycles advance.
  always_ff @(posedge clk) started_q <= !clear_w;

  lcd_com_phase u_phase (
    .clk    (clk),
    .clear  (clear_w),
    .adv    (adv_w),
    .ph_clk (ph_clk_w)
  );

  lcd_com_line #(.LINE_CYC(LINE_CYC)) u_line (
    .clk       (clk),
    .clear     (clear_w),
    .adv       (adv_w),
    .line_end  (line_end_w),
    .line_head (line_head_w),
    .line_clk  (line_clk)
  );

  lcd_com_frame u_frame (
    .clk        (clk),
    .clear      (clear_w),
    .line_end   (line_end_w),
    .line_head  (line_head_w),
    .duty_sel   (duty_sel),
    .frame_end  (frame_end_w),
    .frame_mark (frame_mark),
    .scan_start (scan_start),
    .m_ac       (m_ac)
  );

  assign opclk_a = ph_clk_w[0];
  assign opclk_b = ph_clk_w[1];

endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk (
  input logic clk,
  input logic rst,
  input logic master_en,
  input logic opclk_a,
  input logic opclk_b,
  input logic frame_mark,
  input logic m_ac,
  input logic line_clk,
  input logic scan_start,
  input logic line_end_w,
  input logic frame_end_w
);

  AST_PHASE_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    opclk_a || opclk_b); // R3

  AST_PHASE_LOW_ONE: assert property (@(posedge clk) disable iff (rst || !master_en)
    $fell(opclk_a) |=> opclk_a); // R4

  AST_PHASE_B_TRAILS: assert property (@(posedge clk) disable iff (rst || !master_en)
    $fell(opclk_a) |=> $fell(opclk_b)); // R4

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (opclk_a && opclk_b && !line_clk && !frame_mark && !scan_start && !m_ac)); // R2

  AST_LINE_CLK_FALL: assert property (@(posedge clk) disable iff (rst || !master_en)
    line_end_w |=> $fell(line_clk)); // R5

  AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (rst || !master_en)
    frame_end_w |=> (frame_mark && (m_ac != $past(m_ac)))); // R6

  AST_M_ONLY_AT_MARK: assert property (@(posedge clk) disable iff (rst)
    (!$stable(m_ac) && $past(master_en && !rst)) |-> frame_mark); // R6

  AST_MARK_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> (scan_start && !line_clk)); // R7

  AST_SCAN_RISE_AT_MARK: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_start) |-> frame_mark); // R8

endmodule

bind lcd_com_timing lcd_com_timing_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .master_en   (master_en),
  .opclk_a     (opclk_a),
  .opclk_b     (opclk_b),
  .frame_mark  (frame_mark),
  .m_ac        (m_ac),
  .line_clk    (line_clk),
  .scan_start  (scan_start),
  .line_end_w  (line_end_w),
  .frame_end_w (frame_end_w)
);

// File: tb/lcd_com_timing_tb_top.sv
module lcd_com_timing_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LC         = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       master_en;
  logic [1:0] duty_sel;
  logic       opclk_a, opclk_b, frame_mark, m_ac, line_clk, scan_start;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_com_timing #(.LINE_CYC(LC)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .master_en  (master_en),
    .duty_sel   (duty_sel),
    .opclk_a    (opclk_a),
    .opclk_b    (opclk_b),
    .frame_mark (frame_mark),
    .m_ac       (m_ac),
    .line_clk   (line_clk),
    .scan_start (scan_start)
  );

  function automatic int lines_of(input logic [1:0] c);
    case (c)
      2'b00:   return 48;
      2'b01:   return 64;
      2'b10:   return 96;
      default: return 128;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural model: cycle counts since run start and since frame start.
  bit  run = 0, quiet = 1, mm = 0, cmp_en = 0;
  int  g = 0, k = 0, frame_lines = 48;

  always @(posedge clk) begin
    cyc++;
    if (rst || !master_en) begin
      run = 0; quiet = 1; mm = 0; frame_lines = lines_of(duty_sel);
    end else if (!run) begin
      run = 1; quiet = 0; g = 0; k = 0;
    end else begin
      g++; k++;
      if (k == frame_lines * LC) begin
        k = 0; mm = !mm; frame_lines = lines_of(duty_sel);
      end
    end
    cmp_en = 1;
    if (cyc > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      if (quiet) begin
        check("R2", "idle opclk_a", int'(opclk_a), 1);
        check("R2", "idle opclk_b", int'(opclk_b), 1);
        check("R2", "idle line_clk", int'(line_clk), 0);
        check("R2", "idle frame_mark", int'(frame_mark), 0);
        check("R2", "idle scan_start", int'(scan_start), 0);
        check("R2", "idle m_ac", int'(m_ac), 0);
      end else begin
        check("R4", "opclk_a", int'(opclk_a), int'((g % 4) != 1));
        check("R4", "opclk_b", int'(opclk_b), int'((g % 4) != 2));
        check("R3", "phase overlap", int'(!opclk_a && !opclk_b), 0);
        check("R5", "line_clk", int'(line_clk), int'((k % LC) >= LC / 2));
        check("R7", "frame_mark", int'(frame_mark), int'(k == 0));
        check("R8", "scan_start", int'(scan_start), int'(k < LC));
        check("R6", "m_ac", int'(m_ac), int'(mm));
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Counts falling edges until the next frame marker.
  task automatic wait_mark(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_mark && n < 4000);
  endtask

  initial begin
    int n;
    rst = 1'b1; master_en = 1'b1; duty_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R9", "reset opclk_a", int'(opclk_a), 1);
    check("R9", "reset frame_mark", int'(frame_mark), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "start frame_mark", int'(frame_mark), 1);
    check("R9", "start m_ac", int'(m_ac), 0);
    check("R9", "start opclk_b", int'(opclk_b), 1);

    // R10: a code change in mid-frame leaves the current frame length alone.
    repeat (100) @(negedge clk);
    duty_sel = 2'b11;
    wait_mark(n);
    check("R10", "mid-frame change, old length", n, 48 * LC - 100);
    wait_mark(n);
    check("R10", "next frame new length", n, 128 * LC);

    // R1: every code in turn.
    for (int i = 0; i < 3; i++) begin
      logic [1:0] c;
      c = (i == 0) ? 2'b01 : (i == 1) ? 2'b10 : 2'b00;
      duty_sel = c;
      wait_mark(n);
      wait_mark(n);
      check("R1", "frame length", n, lines_of(c) * LC);
    end

    // R2: slave mode in mid-frame, then a restart.
    repeat (37) @(negedge clk);
    master_en = 1'b0;
    repeat (20) @(negedge clk);
    check("R2", "slave scan_start", int'(scan_start), 0);
    check("R2", "slave opclk_a", int'(opclk_a), 1);
    master_en = 1'b1;
    @(negedge clk);
    check("R2", "restart frame_mark", int'(frame_mark), 1);
    check("R2", "restart m_ac", int'(m_ac), 0);
    wait_mark(n);
    check("R6", "m after first frame", int'(m_ac), 1);

    // R9: reset in mid-frame while the polarity is inverted.
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "reset m_ac", int'(m_ac), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "restart scan_start", int'(scan_start), 1);
    repeat (300) @(negedge clk);
    finish_run();
  end

endmodule